// File: doc/BRIEF.md
# Phase-Frequency Detector with Polarity Select and Lock Indicator

This block sits between the two dividers of a frequency synthesizer and the charge pump. It watches the rising edges of the reference-divider output and the main-divider output. Whichever edge comes first raises a lead flag. That flag stays up until the other edge arrives, and then both flags clear together. The two flags become the pump-up and pump-down requests. The width of each request pulse, counted in clock cycles, equals the edge spacing. A lock indicator is high when neither request is active and low whenever a phase error is being corrected.

A single polarity input does two jobs. It sets the detector sense: with it low, the up and down requests trade places, which suits a loop whose oscillator has a negative tuning slope. It also picks which divider output is sent to a monitor pin. A fast-lock path copies the pump state onto a separate digital output while the load-enable input is high. A companion enable output flags that window. Outside the window the pad driver is meant to float. Both divider inputs are synchronous to the block clock, and all edge detection is done on clock samples.

Top module: `pfd_polarity_lock`

## Requirements
- R1: After a synchronous reset, pump_up and pump_dn are 0, lock_n is 1, and sw_state is 2'b00.
- R2: A rising edge on ref_in, sampled on a clock edge when div_in has no rising edge and no request is active, raises the reference lead. It is visible from the next cycle. With pol_sel=1 it appears on pump_up.
- R3: A rising edge on div_in with no rising edge on ref_in raises the divider lead. With pol_sel=1 it appears on pump_dn.
- R4: A lead stays set until the opposite input has a rising edge. On that clock both leads clear, and rising edges on both inputs in the same cycle raise nothing. The two requests are never high together.
- R5: With pol_sel=0 the reference lead drives pump_dn and the divider lead drives pump_up.
- R6: lock_n is 0 exactly when pump_up or pump_dn is 1.
- R7: mon_out follows ref_in when pol_sel=1 and div_in when pol_sel=0, with no clock delay.
- R8: sw_en equals load_en. While load_en=1, sw_state is 2'b01 when pump_up is 1, 2'b10 when pump_dn is 1, and 2'b00 otherwise. While load_en=0, sw_state is 2'b00.
- R9: An input that stays high, stays low or falls causes no change to the lead flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference-divider output |
| div_in | input | 1 | Main-divider output |
| pol_sel | input | 1 | Polarity select: 1 normal, 0 reversed (also selects the monitor source) |
| load_en | input | 1 | Load enable; high opens the fast-lock window |
| pump_up | output | 1 | Charge-pump source request |
| pump_dn | output | 1 | Charge-pump sink request |
| lock_n | output | 1 | High when no phase error is present |
| mon_out | output | 1 | Monitor of ref_in or div_in |
| sw_en | output | 1 | Fast-lock switch enable |
| sw_state | output | 2 | Pump state for the fast-lock switch (00 idle, 01 source, 10 sink) |

## Verification
The bench goes after edges that land on the same clock. A detector that set a flag before clearing would leave a stray one-cycle request and drop lock_n for no reason. Inputs held high across many cycles are also covered; a level-sensitive design would re-raise a lead that had just cleared. Polarity changes while a lead is pending are mixed in. A design that stored the swapped value, or that tied the monitor to the wrong polarity level, would show the wrong pump line or the wrong divider output. Load enable is toggled while requests are active, so that a switch state leaking outside the window is caught.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Encoding of the pump state offered to the fast-lock switch
    typedef enum logic [1:0] {
        PUMP_IDLE = 2'b00,
        PUMP_SRC  = 2'b01,
        PUMP_SNK  = 2'b10
    } pump_e;

    localparam int NUM_INPUTS = 2;
    localparam int IDX_REF    = 0;
    localparam int IDX_DIV    = 1;

    // Detector state: which divider edge is currently ahead
    typedef struct packed {
        logic ref_lead;
        logic div_lead;
    } lead_t;

    // Pump request pair after the polarity choice
    typedef struct packed {
        logic up;
        logic dn;
    } pump_req_t;

    function automatic pump_req_t apply_polarity(lead_t lead, logic normal);
        pump_req_t r;
        if (normal) begin
            r.up = lead.ref_lead;
            r.dn = lead.div_lead;
        end else begin
            r.up = lead.div_lead;
            r.dn = lead.ref_lead;
        end
        return r;
    endfunction

    function automatic pump_e encode_pump(pump_req_t r);
        if (r.up)      return PUMP_SRC;
        else if (r.dn) return PUMP_SNK;
        else           return PUMP_IDLE;
    endfunction

    function automatic lead_t next_lead(lead_t cur, logic ref_edge, logic div_edge);
        lead_t n;
        n.ref_lead = cur.ref_lead | ref_edge;
        n.div_lead = cur.div_lead | div_edge;
        if (n.ref_lead && n.div_lead) begin
            n = '0;
        end
        return n;
    endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sig_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= sig_in[i];
        end
        assign rise[i] = sig_in[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ref_edge,
    input  logic  div_edge,
    output lead_t lead
);
    lead_t lead_q;

    always_ff @(posedge clk) begin
        if (rst) lead_q <= '0;
        else     lead_q <= next_lead(lead_q, ref_edge, div_edge);
    end

    assign lead = lead_q;
endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage
    import pfd_pkg::*;
(
    input  lead_t       lead,
    input  logic        pol_sel,
    input  logic        load_en,
    input  logic        ref_in,
    input  logic        div_in,
    output logic        pump_up,
    output logic        pump_dn,
    output logic        lock_n,
    output logic        mon_out,
    output logic        sw_en,
    output logic [1:0]  sw_state
);
    pump_req_t req;
    pump_e     st;

    always_comb begin
        req      = apply_polarity(lead, pol_sel);
        st       = encode_pump(req);
        pump_up  = req.up;
        pump_dn  = req.dn;
        lock_n   = ~(lead.ref_lead | lead.div_lead);
        mon_out  = pol_sel ? ref_in : div_in;
        sw_en    = load_en;
        sw_state = load_en ? st : PUMP_IDLE;
    end
endmodule

// File: rtl/pfd_polarity_lock.sv
module pfd_polarity_lock
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_in,
    input  logic       div_in,
    input  logic       pol_sel,
    input  logic       load_en,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       lock_n,
    output logic       mon_out,
    output logic       sw_en,
    output logic [1:0] sw_state
);
    logic [NUM_INPUTS-1:0] raw_in;
    logic [NUM_INPUTS-1:0] rise;
    lead_t                 lead;

    assign raw_in[IDX_REF] = ref_in;
    assign raw_in[IDX_DIV] = div_in;

    pfd_edge_det #(.WIDTH(NUM_INPUTS)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (raw_in),
        .rise   (rise)
    );

    pfd_core u_core (
        .clk      (clk),
        .rst      (rst),
        .ref_edge (rise[IDX_REF]),
        .div_edge (rise[IDX_DIV]),
        .lead     (lead)
    );

    pfd_out_stage u_out (
        .lead     (lead),
        .pol_sel  (pol_sel),
        .load_en  (load_en),
        .ref_in   (ref_in),
        .div_in   (div_in),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .lock_n   (lock_n),
        .mon_out  (mon_out),
        .sw_en    (sw_en),
        .sw_state (sw_state)
    );
endmodule

// File: rtl/pfd_polarity_lock_chk.sv
module pfd_polarity_lock_chk (
    input logic       clk,
    input logic       rst,
    input logic       ref_in,
    input logic       div_in,
    input logic       pol_sel,
    input logic       load_en,
    input logic       pump_up,
    input logic       pump_dn,
    input logic       lock_n,
    input logic       mon_out,
    input logic       sw_en,
    input logic [1:0] sw_state
);
    p_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(pump_up && pump_dn));

    p_lock_r6: assert property (@(posedge clk) disable iff (rst)
        lock_n == !(pump_up || pump_dn));

    p_window_r8: assert property (@(posedge clk) disable iff (rst)
        !sw_en |-> sw_state == 2'b00);

    p_src_r8: assert property (@(posedge clk) disable iff (rst)
        (load_en && pump_up) |-> sw_state == 2'b01);

    p_mon_r7: assert property (@(posedge clk) disable iff (rst)
        mon_out == (pol_sel ? ref_in : div_in));

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(ref_in) && !$rose(div_in) && lock_n) |=> !lock_n);

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!$rose(ref_in) && !$rose(div_in)) |=> $stable(lock_n));
endmodule

bind pfd_polarity_lock pfd_polarity_lock_chk u_chk (.*);

// File: tb/pfd_polarity_lock_bench.sv
module pfd_polarity_lock_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0, div_in = 1'b0, pol_sel = 1'b1, load_en = 1'b0;
    logic pump_up, pump_dn, lock_n, mon_out, sw_en;
    logic [1:0] sw_state;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic m_ref_lead = 1'b0, m_div_lead = 1'b0;
    logic m_ref_prev = 1'b0, m_div_prev = 1'b0;

    always #2.5 clk = ~clk;

    pfd_polarity_lock u_pfd_polarity_lock (.*);

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic exp_up();
        return pol_sel ? m_ref_lead : m_div_lead;
    endfunction
    function automatic logic exp_dn();
        return pol_sel ? m_div_lead : m_ref_lead;
    endfunction
    function automatic logic [1:0] exp_sw();
        if (!load_en)     return 2'b00;
        if (exp_up())     return 2'b01;
        if (exp_dn())     return 2'b10;
        return 2'b00;
    endfunction

    // Apply one cycle of stimulus and check all outputs
    task automatic step(logic r, logic d, logic fc, logic le);
        logic re, de;
        @(negedge clk);
        ref_in = r; div_in = d; pol_sel = fc; load_en = le;
        #1;
        chk("R7 mon_out", {1'b0, mon_out}, {1'b0, fc ? r : d});
        chk("R5 pump after polarity change", {pump_up, pump_dn}, {exp_up(), exp_dn()});
        re = r & ~m_ref_prev;
        de = d & ~m_div_prev;
        @(posedge clk);
        m_ref_prev = r; m_div_prev = d;
        m_ref_lead = m_ref_lead | re;
        m_div_lead = m_div_lead | de;
        if (m_ref_lead && m_div_lead) begin
            m_ref_lead = 1'b0; m_div_lead = 1'b0;
        end
        #1;
        chk(fc ? "R2/R3 pump pair" : "R5 swapped pump pair",
            {pump_up, pump_dn}, {exp_up(), exp_dn()});
        chk("R4 requests exclusive", {1'b0, pump_up & pump_dn}, 2'b00);
        chk("R6 lock_n", {1'b0, lock_n}, {1'b0, !(exp_up() || exp_dn())});
        chk("R8 sw_en", {1'b0, sw_en}, {1'b0, le});
        chk("R8 sw_state", sw_state, exp_sw());
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset pumps", {pump_up, pump_dn}, 2'b00);
        chk("R1 reset lock_n", {1'b0, lock_n}, 2'b01);
        chk("R1 reset sw_state", sw_state, 2'b00);

        // R2: reference leads by three cycles
        step(1, 0, 1, 1);
        chk("R2 ref lead raises pump_up", {pump_up, pump_dn}, 2'b10);
        step(1, 0, 1, 1);
        step(0, 0, 1, 1);
        chk("R9 held/fallen input keeps lead", {pump_up, pump_dn}, 2'b10);
        step(0, 1, 1, 1);
        chk("R4 later edge clears both", {pump_up, pump_dn}, 2'b00);
        step(0, 0, 1, 0);

        // R3: divider leads
        step(0, 1, 1, 1);
        step(0, 0, 1, 1);
        chk("R3 div lead raises pump_dn", {pump_up, pump_dn}, 2'b01);
        chk("R8 sink state", sw_state, 2'b10);
        step(0, 0, 1, 0);
        chk("R8 closed window", sw_state, 2'b00);
        step(1, 0, 1, 0);
        step(0, 0, 1, 0);

        // R4: simultaneous edges raise nothing
        step(1, 1, 1, 1);
        chk("R4 simultaneous edges", {pump_up, pump_dn}, 2'b00);
        step(1, 1, 1, 1);
        step(0, 0, 1, 1);

        // R5: reversed polarity
        step(1, 0, 0, 1);
        chk("R5 ref lead on pump_dn", {pump_up, pump_dn}, 2'b01);
        chk("R5 sink state reversed", sw_state, 2'b10);
        step(0, 0, 1, 1);
        chk("R5 polarity back to normal", {pump_up, pump_dn}, 2'b10);
        step(0, 1, 0, 1);
        step(0, 0, 1, 1);

        // R9: long high level re-raises nothing after clearing
        step(1, 0, 1, 1);
        step(1, 1, 1, 1);
        for (int i = 0; i < 6; i++) step(1, 1, 1, 1);
        chk("R9 held levels stay idle", {pump_up, pump_dn}, 2'b00);
        step(0, 0, 1, 1);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic r, d, fc, le;
            r  = ($urandom % 3) == 0;
            d  = ($urandom % 3) == 0;
            fc = ($urandom % 8) != 0;
            le = ($urandom % 2) == 0;
            step(r, d, fc, le);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule